// File: doc/BRIEF.md
# Tag-Tracking Reservation Station with Condition-Flag Dependencies

This block is the waiting room in front of one functional unit of an out-of-order core. An issue stage hands it a group of up to `ALLOC_W` instructions per cycle, in program order. Each instruction is placed in a free entry, and the index of that entry is the instruction's tag. For every source register the block looks up which older in-flight instruction will produce it, using a register status table. It records that producer's tag, or marks the operand ready when nothing is pending. Condition flags are renamed in the same way. A single global register remembers the tag of the youngest allocated flag writer, and an instruction that reads flags waits on that tag. Operand values are not modelled; only tags and readiness are.

Each cycle the oldest entry whose operands and flags are all resolved is sent to the functional unit. Completing instructions broadcast their tags, up to `BCAST_K` per cycle. A broadcast wakes every waiter on that tag, clears status-table and flag-register slots that still name it, and frees the broadcaster's entry. The count of free entries is output every cycle, so the issue stage never offers more instructions than can be accepted.

Top module: `rs_flag_station`

## Requirements
- R1: Valid allocation slots are taken in slot order, with slot 0 the oldest in program order. Each valid slot gets the lowest-numbered entry that is free and not already taken by an earlier slot of the same group. The entry index is the tag. Entries become occupied at the clock edge that ends the allocating cycle.
- R2: A source operand waits on a tag when an earlier slot of the same group writes its register (the latest such slot wins), or otherwise when the status table holds a pending producer for it. Otherwise the operand is ready.
- R3: An allocated instruction that writes a register becomes that register's pending producer. Later slots in a group override earlier ones.
- R4: An instruction that sets the flags becomes the global flag producer. An instruction that reads the flags waits on the flag producer in force when it is allocated, including an earlier flag-setting slot of its own group. A flag-only dependency blocks dispatch exactly as a register dependency does.
- R5: At most one entry is dispatched per cycle. `disp_valid`/`disp_tag` show it in the same cycle, taken from registered state. An entry is ready when it is occupied, not yet dispatched, and has no unresolved source or flag tag. Among ready entries the oldest by allocation order is chosen, not the lowest tag. A dispatched entry is never dispatched again.
- R6: A broadcast tag in cycle t resolves every matching source and flag wait, and frees the broadcaster's entry. The woken entry can be dispatched in cycle t+1.
- R7: A broadcast clears a status-table or flag-register slot only if that slot still holds the broadcast tag. A newer producer of the same register remains pending.
- R8: A broadcast in the same cycle as an allocation also resolves the dependencies of the instructions allocated in that cycle.
- R9: `free_count` equals the number of unoccupied entries, computed from registered state. It changes only when allocation or a broadcast occurs.
- R10: The number of valid allocation slots in a cycle never exceeds `free_count`. This is guaranteed by the issue stage.
- R11: After reset all entries are free, `free_count` equals `NUM_ENTRIES`, nothing is pending, and `disp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | ALLOC_W | Slot carries an instruction |
| alloc_dst_en | input | ALLOC_W | Slot writes a register |
| alloc_dst | input | ALLOC_W x REG_W | Destination register per slot |
| alloc_src1_en | input | ALLOC_W | First source is used |
| alloc_src1 | input | ALLOC_W x REG_W | First source register per slot |
| alloc_src2_en | input | ALLOC_W | Second source is used |
| alloc_src2 | input | ALLOC_W x REG_W | Second source register per slot |
| alloc_flag_rd | input | ALLOC_W | Slot reads the condition flags |
| alloc_flag_wr | input | ALLOC_W | Slot sets the condition flags |
| bcast_valid | input | BCAST_K | Broadcast lane carries a completed tag |
| bcast_tag | input | BCAST_K x TAG_W | Completed tag per lane |
| disp_valid | output | 1 | An entry is dispatched this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched entry |
| free_count | output | CNT_W | Number of free entries |

## Verification
The hardest state to reach from the ports is one where a younger instruction sits in a lower-numbered entry than an older one, and both become ready in the same cycle. Only then does age order differ from tag order. A directed sequence creates it. An older consumer is held on a slow producer while a low entry is freed and refilled. The producer is then broadcast in the same cycle as the refill, so both entries wake together. Same-cycle broadcast-and-allocate and a stale status-table slot are also steered by directed sequences. A long stretch of seeded random groups over few registers then has every cycle compared with a bench model of tags, ages and the status table.

// File: rtl/rs_pkg.sv
// Package: default sizing shared by the reservation station and its bench.
// Assumes the entry count and register count are powers of two.
package rs_pkg;
    localparam int RS_ENTRIES  = 8;
    localparam int RS_ALLOC_W  = 2;
    localparam int RS_BCAST_K  = 2;
    localparam int RS_REGS     = 16;
endpackage

// File: rtl/rs_slot_map.sv
// Maps allocation slots to free entries, lowest index first in slot order,
// and reports the free entry count. Assumes the caller never offers more
// valid slots than there are free entries.
module rs_slot_map #(
    parameter int NUM_ENTRIES = 8,
    parameter int ALLOC_W     = 2,
    localparam int TAG_W      = $clog2(NUM_ENTRIES),
    localparam int SLOT_W     = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1,
    localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
    input  logic [NUM_ENTRIES-1:0]             occ,
    input  logic [ALLOC_W-1:0]                 alloc_valid,
    output logic [ALLOC_W-1:0][TAG_W-1:0]      slot_entry,
    output logic [NUM_ENTRIES-1:0]             new_mask,
    output logic [NUM_ENTRIES-1:0][SLOT_W-1:0] new_slot,
    output logic [CNT_W-1:0]                   free_count
);
    logic [NUM_ENTRIES-1:0] avail;
    logic                   found;

    // Purpose: hand out the lowest free entries to valid slots in order.
    always_comb begin
        avail      = ~occ;
        new_mask   = '0;
        new_slot   = '0;
        slot_entry = '0;
        found      = 1'b0;
        for (int s = 0; s < ALLOC_W; s++) begin
            found = 1'b0;
            if (alloc_valid[s]) begin
                for (int i = 0; i < NUM_ENTRIES; i++) begin
                    if (!found && avail[i]) begin
                        found         = 1'b1;
                        avail[i]      = 1'b0;
                        slot_entry[s] = TAG_W'(i);
                        new_mask[i]   = 1'b1;
                        new_slot[i]   = SLOT_W'(s);
                    end
                end
            end
        end
    end

    // Purpose: count unoccupied entries.
    always_comb begin
        free_count = CNT_W'(NUM_ENTRIES);
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (occ[i]) free_count = free_count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/rs_dep_track.sv
// Register status table plus global flag-producer register. Looks up the
// producer tag of every source and of the flags for each slot, honouring
// earlier slots of the same group and same-cycle broadcasts. Updates the
// table with broadcasts (only on tag match) and with new destinations.
module rs_dep_track #(
    parameter int NUM_ENTRIES = 8,
    parameter int ALLOC_W     = 2,
    parameter int BCAST_K     = 2,
    parameter int NUM_REGS    = 16,
    localparam int TAG_W      = $clog2(NUM_ENTRIES),
    localparam int REG_W      = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ALLOC_W-1:0]             alloc_valid,
    input  logic [ALLOC_W-1:0]             alloc_dst_en,
    input  logic [ALLOC_W-1:0][REG_W-1:0]  alloc_dst,
    input  logic [ALLOC_W-1:0]             alloc_src1_en,
    input  logic [ALLOC_W-1:0][REG_W-1:0]  alloc_src1,
    input  logic [ALLOC_W-1:0]             alloc_src2_en,
    input  logic [ALLOC_W-1:0][REG_W-1:0]  alloc_src2,
    input  logic [ALLOC_W-1:0]             alloc_flag_rd,
    input  logic [ALLOC_W-1:0]             alloc_flag_wr,
    input  logic [ALLOC_W-1:0][TAG_W-1:0]  slot_entry,
    input  logic [BCAST_K-1:0]             bcast_valid,
    input  logic [BCAST_K-1:0][TAG_W-1:0]  bcast_tag,
    output logic [ALLOC_W-1:0]             lk_w1,
    output logic [ALLOC_W-1:0][TAG_W-1:0]  lk_t1,
    output logic [ALLOC_W-1:0]             lk_w2,
    output logic [ALLOC_W-1:0][TAG_W-1:0]  lk_t2,
    output logic [ALLOC_W-1:0]             lk_wf,
    output logic [ALLOC_W-1:0][TAG_W-1:0]  lk_tf
);
    logic [NUM_REGS-1:0]            rt_busy, rt_busy_n;
    logic [NUM_REGS-1:0][TAG_W-1:0] rt_tag, rt_tag_n;
    logic                           fl_busy, fl_busy_n;
    logic [TAG_W-1:0]               fl_tag, fl_tag_n;
    logic                           b1, b2, bf;
    logic [TAG_W-1:0]               t1, t2, tf;

    function automatic logic tag_hit(input logic [TAG_W-1:0] t);
        logic h = 1'b0;
        for (int k = 0; k < BCAST_K; k++) begin
            if (bcast_valid[k] && bcast_tag[k] == t) h = 1'b1;
        end
        return h;
    endfunction

    // Purpose: resolve each slot's source and flag producers.
    always_comb begin
        b1 = 1'b0; b2 = 1'b0; bf = 1'b0;
        t1 = '0;   t2 = '0;   tf = '0;
        lk_w1 = '0; lk_t1 = '0; lk_w2 = '0; lk_t2 = '0; lk_wf = '0; lk_tf = '0;
        for (int s = 0; s < ALLOC_W; s++) begin
            b1 = rt_busy[alloc_src1[s]]; t1 = rt_tag[alloc_src1[s]];
            b2 = rt_busy[alloc_src2[s]]; t2 = rt_tag[alloc_src2[s]];
            bf = fl_busy;                tf = fl_tag;
            for (int p = 0; p < s; p++) begin
                if (alloc_valid[p] && alloc_dst_en[p] && alloc_dst[p] == alloc_src1[s]) begin
                    b1 = 1'b1; t1 = slot_entry[p];
                end
                if (alloc_valid[p] && alloc_dst_en[p] && alloc_dst[p] == alloc_src2[s]) begin
                    b2 = 1'b1; t2 = slot_entry[p];
                end
                if (alloc_valid[p] && alloc_flag_wr[p]) begin
                    bf = 1'b1; tf = slot_entry[p];
                end
            end
            lk_w1[s] = alloc_valid[s] && alloc_src1_en[s] && b1 && !tag_hit(t1);
            lk_w2[s] = alloc_valid[s] && alloc_src2_en[s] && b2 && !tag_hit(t2);
            lk_wf[s] = alloc_valid[s] && alloc_flag_rd[s] && bf && !tag_hit(tf);
            lk_t1[s] = t1;
            lk_t2[s] = t2;
            lk_tf[s] = tf;
        end
    end

    // Purpose: next table state, broadcast clears first, then new producers.
    always_comb begin
        rt_busy_n = rt_busy;
        rt_tag_n  = rt_tag;
        fl_busy_n = fl_busy && !tag_hit(fl_tag);
        fl_tag_n  = fl_tag;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rt_busy[r] && tag_hit(rt_tag[r])) rt_busy_n[r] = 1'b0;
        end
        for (int s = 0; s < ALLOC_W; s++) begin
            if (alloc_valid[s] && alloc_dst_en[s]) begin
                rt_busy_n[alloc_dst[s]] = 1'b1;
                rt_tag_n[alloc_dst[s]]  = slot_entry[s];
            end
            if (alloc_valid[s] && alloc_flag_wr[s]) begin
                fl_busy_n = 1'b1;
                fl_tag_n  = slot_entry[s];
            end
        end
    end

    // Purpose: hold the status table and flag producer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_busy <= '0;
            rt_tag  <= '0;
            fl_busy <= 1'b0;
            fl_tag  <= '0;
        end else begin
            rt_busy <= rt_busy_n;
            rt_tag  <= rt_tag_n;
            fl_busy <= fl_busy_n;
            fl_tag  <= fl_tag_n;
        end
    end
endmodule

// File: rtl/rs_age_pick.sv
// Age matrix over the entries and oldest-ready selection. older[j][i] set
// means entry j was allocated before entry i. Assumes new entries are only
// placed in entries that are free.
module rs_age_pick #(
    parameter int NUM_ENTRIES = 8,
    parameter int ALLOC_W     = 2,
    localparam int TAG_W      = $clog2(NUM_ENTRIES),
    localparam int SLOT_W     = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_ENTRIES-1:0]              new_mask,
    input  logic [NUM_ENTRIES-1:0][SLOT_W-1:0]  new_slot,
    input  logic [NUM_ENTRIES-1:0]              ready,
    output logic                                disp_valid,
    output logic [TAG_W-1:0]                    disp_tag
);
    logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] older, older_n;
    logic                                    blocked, got;

    // Purpose: order new entries after all existing ones and by slot.
    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            for (int j = 0; j < NUM_ENTRIES; j++) begin
                if (new_mask[i] && new_mask[j])
                    older_n[i][j] = new_slot[i] < new_slot[j];
                else if (new_mask[i])
                    older_n[i][j] = 1'b0;
                else if (new_mask[j])
                    older_n[i][j] = 1'b1;
                else
                    older_n[i][j] = older[i][j];
            end
        end
    end

    // Purpose: pick the ready entry with no older ready entry.
    always_comb begin
        got      = 1'b0;
        blocked  = 1'b0;
        disp_tag = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            blocked = 1'b0;
            for (int j = 0; j < NUM_ENTRIES; j++) begin
                if (ready[j] && older[j][i]) blocked = 1'b1;
            end
            if (ready[i] && !blocked && !got) begin
                got      = 1'b1;
                disp_tag = TAG_W'(i);
            end
        end
        disp_valid = got;
    end

    // Purpose: hold the age matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) older <= '0;
        else        older <= older_n;
    end
endmodule

// File: rtl/rs_flag_station.sv
// Reservation station for one functional unit with register and condition
// flag dependency tracking by producer tag. Accepts up to ALLOC_W
// instructions per cycle, dispatches the oldest ready one per cycle and
// frees entries on result broadcast. Assumes the issue stage respects
// free_count and only broadcasts tags that were dispatched.
module rs_flag_station #(
    parameter int NUM_ENTRIES = rs_pkg::RS_ENTRIES,
    parameter int ALLOC_W     = rs_pkg::RS_ALLOC_W,
    parameter int BCAST_K     = rs_pkg::RS_BCAST_K,
    parameter int NUM_REGS    = rs_pkg::RS_REGS,
    localparam int TAG_W      = $clog2(NUM_ENTRIES),
    localparam int REG_W      = $clog2(NUM_REGS),
    localparam int CNT_W      = $clog2(NUM_ENTRIES + 1),
    localparam int SLOT_W     = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ALLOC_W-1:0]             alloc_valid,
    input  logic [ALLOC_W-1:0]             alloc_dst_en,
    input  logic [ALLOC_W-1:0][REG_W-1:0]  alloc_dst,
    input  logic [ALLOC_W-1:0]             alloc_src1_en,
    input  logic [ALLOC_W-1:0][REG_W-1:0]  alloc_src1,
    input  logic [ALLOC_W-1:0]             alloc_src2_en,
    input  logic [ALLOC_W-1:0][REG_W-1:0]  alloc_src2,
    input  logic [ALLOC_W-1:0]             alloc_flag_rd,
    input  logic [ALLOC_W-1:0]             alloc_flag_wr,
    input  logic [BCAST_K-1:0]             bcast_valid,
    input  logic [BCAST_K-1:0][TAG_W-1:0]  bcast_tag,
    output logic                           disp_valid,
    output logic [TAG_W-1:0]               disp_tag,
    output logic [CNT_W-1:0]               free_count
);
    logic [NUM_ENTRIES-1:0]             ent_valid, ent_issued;
    logic [NUM_ENTRIES-1:0]             ent_w1, ent_w2, ent_wf;
    logic [NUM_ENTRIES-1:0][TAG_W-1:0]  ent_t1, ent_t2, ent_tf;
    logic [NUM_ENTRIES-1:0]             ready;
    logic [ALLOC_W-1:0][TAG_W-1:0]      slot_entry;
    logic [NUM_ENTRIES-1:0]             new_mask;
    logic [NUM_ENTRIES-1:0][SLOT_W-1:0] new_slot;
    logic [ALLOC_W-1:0]                 lk_w1, lk_w2, lk_wf;
    logic [ALLOC_W-1:0][TAG_W-1:0]      lk_t1, lk_t2, lk_tf;

    function automatic logic tag_hit(input logic [TAG_W-1:0] t);
        logic h = 1'b0;
        for (int k = 0; k < BCAST_K; k++) begin
            if (bcast_valid[k] && bcast_tag[k] == t) h = 1'b1;
        end
        return h;
    endfunction

    rs_slot_map #(.NUM_ENTRIES(NUM_ENTRIES), .ALLOC_W(ALLOC_W)) u_map (
        .occ(ent_valid), .alloc_valid(alloc_valid), .slot_entry(slot_entry),
        .new_mask(new_mask), .new_slot(new_slot), .free_count(free_count)
    );

    rs_dep_track #(.NUM_ENTRIES(NUM_ENTRIES), .ALLOC_W(ALLOC_W),
                   .BCAST_K(BCAST_K), .NUM_REGS(NUM_REGS)) u_dep (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
        .alloc_dst_en(alloc_dst_en), .alloc_dst(alloc_dst),
        .alloc_src1_en(alloc_src1_en), .alloc_src1(alloc_src1),
        .alloc_src2_en(alloc_src2_en), .alloc_src2(alloc_src2),
        .alloc_flag_rd(alloc_flag_rd), .alloc_flag_wr(alloc_flag_wr),
        .slot_entry(slot_entry), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
        .lk_w1(lk_w1), .lk_t1(lk_t1), .lk_w2(lk_w2), .lk_t2(lk_t2),
        .lk_wf(lk_wf), .lk_tf(lk_tf)
    );

    // Purpose: an entry may go when occupied, not yet sent, and unblocked.
    assign ready = ent_valid & ~ent_issued & ~ent_w1 & ~ent_w2 & ~ent_wf;

    rs_age_pick #(.NUM_ENTRIES(NUM_ENTRIES), .ALLOC_W(ALLOC_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .new_mask(new_mask), .new_slot(new_slot),
        .ready(ready), .disp_valid(disp_valid), .disp_tag(disp_tag)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        // Purpose: fill, wake, mark dispatched and free one entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[i]  <= 1'b0;
                ent_issued[i] <= 1'b0;
                ent_w1[i]     <= 1'b0;
                ent_w2[i]     <= 1'b0;
                ent_wf[i]     <= 1'b0;
                ent_t1[i]     <= '0;
                ent_t2[i]     <= '0;
                ent_tf[i]     <= '0;
            end else if (new_mask[i]) begin
                ent_valid[i]  <= 1'b1;
                ent_issued[i] <= 1'b0;
                ent_w1[i]     <= lk_w1[new_slot[i]];
                ent_w2[i]     <= lk_w2[new_slot[i]];
                ent_wf[i]     <= lk_wf[new_slot[i]];
                ent_t1[i]     <= lk_t1[new_slot[i]];
                ent_t2[i]     <= lk_t2[new_slot[i]];
                ent_tf[i]     <= lk_tf[new_slot[i]];
            end else if (ent_valid[i]) begin
                if (tag_hit(TAG_W'(i))) ent_valid[i] <= 1'b0;
                if (disp_valid && disp_tag == TAG_W'(i)) ent_issued[i] <= 1'b1;
                ent_w1[i] <= ent_w1[i] && !tag_hit(ent_t1[i]);
                ent_w2[i] <= ent_w2[i] && !tag_hit(ent_t2[i]);
                ent_wf[i] <= ent_wf[i] && !tag_hit(ent_tf[i]);
            end
        end
    end
endmodule

// File: rtl/rs_flag_station_chk.sv
// Checker for rs_flag_station, attached by bind. Watches ports and the
// entry occupancy/dispatch state of the station.
module rs_flag_station_chk #(
    parameter int NUM_ENTRIES = 8,
    parameter int ALLOC_W     = 2,
    parameter int BCAST_K     = 2,
    localparam int TAG_W      = $clog2(NUM_ENTRIES),
    localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ALLOC_W-1:0]            alloc_valid,
    input logic [BCAST_K-1:0]            bcast_valid,
    input logic [BCAST_K-1:0][TAG_W-1:0] bcast_tag,
    input logic                          disp_valid,
    input logic [TAG_W-1:0]              disp_tag,
    input logic [CNT_W-1:0]              free_count,
    input logic [NUM_ENTRIES-1:0]        ent_valid,
    input logic [NUM_ENTRIES-1:0]        ent_issued
);
    assert_alloc_fits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alloc_valid) <= int'(free_count));

    assert_disp_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ent_valid[disp_tag] && !ent_issued[disp_tag]);

    assert_disp_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> ent_valid[$past(disp_tag)] && ent_issued[$past(disp_tag)]);

    assert_bcast_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid[0] && ent_valid[bcast_tag[0]] |=> !ent_valid[$past(bcast_tag[0])]);

    assert_count_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid == '0 && bcast_valid == '0) |=> $stable(free_count));
endmodule

bind rs_flag_station rs_flag_station_chk #(
    .NUM_ENTRIES(NUM_ENTRIES), .ALLOC_W(ALLOC_W), .BCAST_K(BCAST_K)
) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .free_count(free_count),
    .ent_valid(ent_valid), .ent_issued(ent_issued)
);

// File: tb/rs_flag_station_tb.sv
// Bench for rs_flag_station: directed corner cases, then seeded random
// groups, every cycle compared with a bench model built from the brief.
module rs_flag_station_tb;
    localparam int N  = 8;
    localparam int W  = 2;
    localparam int K  = 2;
    localparam int R  = 16;
    localparam int TW = 3;
    localparam int RW = 4;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] alloc_valid, alloc_dst_en, alloc_src1_en, alloc_src2_en;
    logic [W-1:0] alloc_flag_rd, alloc_flag_wr;
    logic [W-1:0][RW-1:0] alloc_dst, alloc_src1, alloc_src2;
    logic [K-1:0] bcast_valid;
    logic [K-1:0][TW-1:0] bcast_tag;
    logic disp_valid;
    logic [TW-1:0] disp_tag;
    logic [CW-1:0] free_count;

    always #2 clk = ~clk;

    rs_flag_station #(.NUM_ENTRIES(N), .ALLOC_W(W), .BCAST_K(K), .NUM_REGS(R)) u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
        .alloc_dst_en(alloc_dst_en), .alloc_dst(alloc_dst),
        .alloc_src1_en(alloc_src1_en), .alloc_src1(alloc_src1),
        .alloc_src2_en(alloc_src2_en), .alloc_src2(alloc_src2),
        .alloc_flag_rd(alloc_flag_rd), .alloc_flag_wr(alloc_flag_wr),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .free_count(free_count)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // model state
    bit m_valid[N], m_iss[N], m_w1[N], m_w2[N], m_wf[N];
    int m_t1[N], m_t2[N], m_tf[N], m_seq[N];
    bit rt_busy[R];
    int rt_tag[R];
    bit fl_busy;
    int fl_tag;
    int seq_ctr;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int m_free();
        int n = 0;
        for (int i = 0; i < N; i++) if (!m_valid[i]) n++;
        return n;
    endfunction

    function automatic int m_pick();
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (m_valid[i] && !m_iss[i] && !m_w1[i] && !m_w2[i] && !m_wf[i])
                if (best < 0 || m_seq[i] < m_seq[best]) best = i;
        end
        return best;
    endfunction

    function automatic bit bc_hit(input int t);
        bit h = 0;
        for (int k = 0; k < K; k++) if (bcast_valid[k] && int'(bcast_tag[k]) == t) h = 1;
        return h;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_iss[i] = 0; m_w1[i] = 0; m_w2[i] = 0; m_wf[i] = 0;
            m_t1[i] = 0; m_t2[i] = 0; m_tf[i] = 0; m_seq[i] = 0;
        end
        for (int r = 0; r < R; r++) begin rt_busy[r] = 0; rt_tag[r] = 0; end
        fl_busy = 0; fl_tag = 0; seq_ctr = 0;
    endtask

    // Advance the model by one clock using the current inputs.
    task automatic model_advance();
        int d = m_pick();
        int ent[W];
        bit used[N];
        bit nw1[W], nw2[W], nwf[W];
        int nt1[W], nt2[W], ntf[W];
        for (int i = 0; i < N; i++) used[i] = m_valid[i];
        for (int s = 0; s < W; s++) begin
            bit b1, b2, bf;
            ent[s] = 0; nw1[s] = 0; nw2[s] = 0; nwf[s] = 0;
            nt1[s] = 0; nt2[s] = 0; ntf[s] = 0;
            if (alloc_valid[s]) begin
                for (int i = N - 1; i >= 0; i--) if (!used[i]) ent[s] = i;
                used[ent[s]] = 1;
                b1 = rt_busy[alloc_src1[s]]; nt1[s] = rt_tag[alloc_src1[s]];
                b2 = rt_busy[alloc_src2[s]]; nt2[s] = rt_tag[alloc_src2[s]];
                bf = fl_busy; ntf[s] = fl_tag;
                for (int p = 0; p < s; p++) begin
                    if (alloc_valid[p] && alloc_dst_en[p] && alloc_dst[p] == alloc_src1[s]) begin b1 = 1; nt1[s] = ent[p]; end
                    if (alloc_valid[p] && alloc_dst_en[p] && alloc_dst[p] == alloc_src2[s]) begin b2 = 1; nt2[s] = ent[p]; end
                    if (alloc_valid[p] && alloc_flag_wr[p]) begin bf = 1; ntf[s] = ent[p]; end
                end
                nw1[s] = alloc_src1_en[s] && b1 && !bc_hit(nt1[s]);
                nw2[s] = alloc_src2_en[s] && b2 && !bc_hit(nt2[s]);
                nwf[s] = alloc_flag_rd[s] && bf && !bc_hit(ntf[s]);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (m_valid[i]) begin
                if (m_w1[i] && bc_hit(m_t1[i])) m_w1[i] = 0;
                if (m_w2[i] && bc_hit(m_t2[i])) m_w2[i] = 0;
                if (m_wf[i] && bc_hit(m_tf[i])) m_wf[i] = 0;
                if (i == d) m_iss[i] = 1;
                if (bc_hit(i)) m_valid[i] = 0;
            end
        end
        for (int r = 0; r < R; r++) if (rt_busy[r] && bc_hit(rt_tag[r])) rt_busy[r] = 0;
        if (fl_busy && bc_hit(fl_tag)) fl_busy = 0;
        for (int s = 0; s < W; s++) begin
            if (alloc_valid[s]) begin
                if (alloc_dst_en[s]) begin rt_busy[alloc_dst[s]] = 1; rt_tag[alloc_dst[s]] = ent[s]; end
                if (alloc_flag_wr[s]) begin fl_busy = 1; fl_tag = ent[s]; end
                m_valid[ent[s]] = 1; m_iss[ent[s]] = 0;
                m_w1[ent[s]] = nw1[s]; m_t1[ent[s]] = nt1[s];
                m_w2[ent[s]] = nw2[s]; m_t2[ent[s]] = nt2[s];
                m_wf[ent[s]] = nwf[s]; m_tf[ent[s]] = ntf[s];
                m_seq[ent[s]] = seq_ctr++;
            end
        end
    endtask

    task automatic compare();
        int d = m_pick();
        check(disp_valid == (d >= 0), "R5 disp_valid vs model", int'(disp_valid), int'(d >= 0));
        if (d >= 0) check(int'(disp_tag) == d, "R5 oldest-ready disp_tag vs model", int'(disp_tag), d);
        check(int'(free_count) == m_free(), "R9 free_count vs model", int'(free_count), m_free());
    endtask

    task automatic clear_inputs();
        alloc_valid = '0; alloc_dst_en = '0; alloc_src1_en = '0; alloc_src2_en = '0;
        alloc_flag_rd = '0; alloc_flag_wr = '0;
        alloc_dst = '0; alloc_src1 = '0; alloc_src2 = '0;
        bcast_valid = '0; bcast_tag = '0;
    endtask

    // slot fields: dst enable/reg, src1 enable/reg, src2 enable/reg, flag read, flag write
    task automatic set_slot(input int s, input bit de, input int dr, input bit e1, input int r1,
                            input bit e2, input int r2, input bit fr, input bit fw);
        alloc_valid[s] = 1; alloc_dst_en[s] = de; alloc_dst[s] = RW'(dr);
        alloc_src1_en[s] = e1; alloc_src1[s] = RW'(r1);
        alloc_src2_en[s] = e2; alloc_src2[s] = RW'(r2);
        alloc_flag_rd[s] = fr; alloc_flag_wr[s] = fw;
    endtask

    task automatic set_bc(input int k, input int t);
        bcast_valid[k] = 1; bcast_tag[k] = TW'(t);
    endtask

    // One cycle: inputs already set at the negedge; model follows the edge.
    task automatic tick();
        model_advance();
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
        compare();
    endtask

    task automatic expect_disp(input bit v, input int t, input string req);
        check(disp_valid == v, req, int'(disp_valid), int'(v));
        if (v) check(int'(disp_tag) == t, req, int'(disp_tag), t);
    endtask

    // Broadcast random dispatched entries, up to K distinct.
    task automatic random_bcast(input int pct);
        bit taken[N];
        for (int i = 0; i < N; i++) taken[i] = 0;
        for (int k = 0; k < K; k++) begin
            if ($urandom_range(0, 99) < pct) begin
                int st = $urandom_range(0, N - 1);
                for (int o = 0; o < N; o++) begin
                    int i = (st + o) % N;
                    if (!bcast_valid[k] && m_valid[i] && m_iss[i] && !taken[i]) begin
                        taken[i] = 1; set_bc(k, i);
                    end
                end
            end
        end
    endtask

    task automatic drain();
        int guard = 0;
        while (m_free() != N && guard < 200) begin
            random_bcast(100);
            tick();
            guard++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        clear_inputs();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check(int'(free_count) == N, "R11 free_count after reset", int'(free_count), N);
        check(disp_valid == 1'b0, "R11 disp_valid after reset", int'(disp_valid), 0);

        // A: in-group register and flag dependency
        set_slot(0, 1, 1, 0, 0, 0, 0, 0, 1);
        set_slot(1, 0, 0, 1, 1, 0, 0, 1, 0);
        tick();
        expect_disp(1, 0, "R1 slot0 takes entry 0 and dispatches");
        check(int'(free_count) == 6, "R9 two entries taken", int'(free_count), 6);
        tick();
        expect_disp(0, 0, "R2 later slot waits on earlier slot producer");
        set_bc(0, 0);
        tick();
        expect_disp(1, 1, "R6 woken entry 1 dispatches next cycle");
        check(int'(free_count) == 7, "R6 broadcaster entry freed", int'(free_count), 7);
        drain();

        // B: flag-only dependency
        set_slot(0, 0, 0, 0, 0, 0, 0, 0, 1);
        set_slot(1, 0, 0, 0, 0, 0, 0, 1, 0);
        tick();
        expect_disp(1, 0, "R4 flag setter dispatches");
        tick();
        expect_disp(0, 0, "R4 flag reader blocked on flag producer");
        set_bc(0, 0);
        tick();
        expect_disp(1, 1, "R4 flag reader released by broadcast");
        drain();

        // C: broadcast in the same cycle as allocation of a consumer
        set_slot(0, 1, 5, 0, 0, 0, 0, 0, 0);
        tick();
        expect_disp(1, 0, "R3 producer of r5 dispatches");
        tick();
        expect_disp(0, 0, "R3 station idle after producer sent");
        set_bc(0, 0);
        set_slot(0, 0, 0, 1, 5, 0, 0, 0, 0);
        tick();
        expect_disp(1, 1, "R8 same-cycle broadcast resolves new entry");
        drain();

        // D: stale status-table entry kept by newer producer
        set_slot(0, 1, 2, 0, 0, 0, 0, 0, 0);
        set_slot(1, 1, 2, 0, 0, 0, 0, 0, 0);
        tick();
        tick();
        expect_disp(1, 1, "R3 second writer dispatches");
        set_bc(0, 0);
        tick();
        set_slot(0, 0, 0, 1, 2, 0, 0, 0, 0);
        tick();
        expect_disp(0, 0, "R7 reader of r2 waits on newer producer");
        set_bc(0, 1);
        tick();
        expect_disp(1, 0, "R7 reader released by newer producer");
        drain();

        // E: younger instruction in a lower entry than an older one
        set_slot(0, 0, 0, 0, 0, 0, 0, 0, 0);
        set_slot(1, 1, 1, 0, 0, 0, 0, 0, 0);
        tick();
        set_slot(0, 0, 0, 1, 1, 0, 0, 0, 0);
        tick();
        expect_disp(1, 1, "R5 producer in entry 1 dispatches");
        set_bc(0, 0);
        tick();
        expect_disp(0, 0, "R5 consumer in entry 2 still waits");
        set_bc(0, 1);
        set_slot(0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick();
        expect_disp(1, 2, "R5 older entry 2 beats younger entry 0");
        tick();
        expect_disp(1, 0, "R5 younger entry 0 follows");
        drain();

        // Full station
        for (int c = 0; c < 4; c++) begin
            set_slot(0, 0, 0, 0, 0, 0, 0, 0, 0);
            set_slot(1, 0, 0, 0, 0, 0, 0, 0, 0);
            tick();
        end
        check(int'(free_count) == 0, "R10 station full, free_count zero", int'(free_count), 0);
        tick();
        check(int'(free_count) == 0, "R9 count holds with no activity", int'(free_count), 0);
        drain();

        // Random phase
        for (int c = 0; c < 3000; c++) begin
            int n = $urandom_range(0, W);
            if (n > m_free()) n = m_free();
            for (int s = 0; s < n; s++)
                set_slot(s, 1'($urandom_range(0, 1)), $urandom_range(0, 5),
                         1'($urandom_range(0, 1)), $urandom_range(0, 5),
                         1'($urandom_range(0, 1)), $urandom_range(0, 5),
                         1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
            random_bcast(40);
            tick();
        end
        drain();
        check(int'(free_count) == N, "R9 all entries free after drain", int'(free_count), N);
        finish_run();
    end
endmodule